// File: doc/BRIEF.md
# Three-Port General-Purpose I/O with Pad-Drive Decode

This block gives software three byte-wide general-purpose ports in a small I/O address space. Each port keeps an output latch and one 2-bit drive mode that every pin of the port shares. From the mode and each pin's latched bit, the block produces three pad controls per pin: a weak pull-up enable, a low-side sink enable and a high-side source enable. The analog pad is outside the block. Only these digital controls leave it.

Reading a port's data address does not return the latch. It returns the pad levels after a two-flop synchronizer. Every change on a synchronized pin, rising or falling, sets a sticky change flag. Software clears these flags by writing ones. Each pin has its own interrupt enable, and an enabled pin whose flag is set raises the single interrupt-request output.

Top module: `gpio_trio`

## Requirements
- R1: A write to address 0x00+p (p = 0..2) loads the output latch of port p. The new value governs that port's pad controls from the clock edge that accepts the write.
- R2: A write to address 0x08 sets the port modes, with port p in bits [2p+1:2p]: 00 pulled-up input, 01 push-pull output, 10 open drain, 11 floating with every driver off. A read of 0x08 returns the six mode bits in the low bits.
- R3: A pin's pull-up enable is 1 exactly when its port mode is 00 and its latch bit is 1.
- R4: A pin's sink enable is 1 exactly when its latch bit is 0 and its port mode is not 11. Sink is never active together with pull-up or source on the same pin.
- R5: A pin's source enable is 1 exactly when its port mode is 01 and its latch bit is 1.
- R6: In open-drain mode, a pin whose latch bit is 1 has pull-up, sink and source all off.
- R7: A read of 0x00+p returns port p's pad levels through two synchronizer flops. A pad change made between two clock edges shows on the read after the second following edge, and not after the first.
- R8: After reset, every latch holds all ones, every mode is 00, and all interrupt enables and change flags are zero. As a result every pull-up is on, every sink and source is off, and the interrupt request is low.
- R9: Address 0x04+p holds port p's per-pin interrupt enables and can be read back.
- R10: Any change of a synchronized pin sets its flag, read at 0x0C+p, one edge after the change reaches the read path. A flag stays set until a write of 1 to its bit at 0x0C+p. A new change in the same cycle as the clearing write wins.
- R11: The interrupt request is high exactly when some pin has both its flag and its interrupt enable set.
- R12: Reads of unmapped addresses return zero. Writes to unmapped addresses change no pad control, enable or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| pad_in | input | 24 | Pad input levels, port p at bits [8p+7:8p] |
| pull_en | output | 24 | Per-pin pull-up enable |
| sink_en | output | 24 | Per-pin low-side drive enable |
| src_en | output | 24 | Per-pin high-side drive enable |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted latch or mode register shows on the pad-control outputs in the cycle after the write that set it. Every drive bus is therefore compared against a model of the decode after each random write. A synchronizer with the wrong depth moves the data-read transition by one cycle, so the read is sampled on both sides of the expected edge. A change flag that is lost or sticks shows on the flag read and on irq within three cycles of a pad change. The same-cycle set-versus-clear race gets a directed case.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned GP_PORTS  = 3;
    localparam int unsigned GP_WIDTH  = 8;
    localparam int unsigned GP_ADDR_W = 8;

    // register map bases
    localparam int unsigned GP_DATA_BASE = 'h00;
    localparam int unsigned GP_IE_BASE   = 'h04;
    localparam int unsigned GP_MODE_ADDR = 'h08;
    localparam int unsigned GP_FLAG_BASE = 'h0C;

    typedef enum logic [1:0] {
        MODE_PULLUP    = 2'b00,
        MODE_PUSHPULL  = 2'b01,
        MODE_OPENDRAIN = 2'b10,
        MODE_FLOAT     = 2'b11
    } pad_mode_e;

endpackage

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
    import gpio_pkg::*;
#(
    parameter int unsigned PORT_W = GP_WIDTH
) (
    input  pad_mode_e          mode,
    input  logic [PORT_W-1:0]  dout,
    output logic [PORT_W-1:0]  pull_o,
    output logic [PORT_W-1:0]  sink_o,
    output logic [PORT_W-1:0]  src_o
);

    logic is_pullup;
    logic is_push;
    logic is_float;

    assign is_pullup = (mode == MODE_PULLUP);
    assign is_push   = (mode == MODE_PUSHPULL);
    assign is_float  = (mode == MODE_FLOAT);

    // open drain falls out: neither pull-up nor source, sink only on a 0
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        assign pull_o[b] = is_pullup & dout[b];
        assign sink_o[b] = ~is_float & ~dout[b];
        assign src_o[b]  = is_push & dout[b];
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned PINS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_i,
    output logic [PINS-1:0] lvl_o,
    output logic [PINS-1:0] chg_o
);

    typedef struct packed {
        logic [PINS-1:0] s1;
        logic [PINS-1:0] s2;
        logic [PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pad_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    // pins come up pulled high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: '1, s2: '1, prev: '1};
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.s2;
    assign chg_o = st_q.s2 ^ st_q.prev;

endmodule

// File: rtl/gpio_trio.sv
module gpio_trio
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PORTS = GP_PORTS,
    parameter int unsigned PORT_W    = GP_WIDTH,
    parameter int unsigned ADDR_W    = GP_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [PORT_W-1:0]             wdata,
    output logic [PORT_W-1:0]             rdata,
    input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pull_en,
    output logic [NUM_PORTS*PORT_W-1:0]   sink_en,
    output logic [NUM_PORTS*PORT_W-1:0]   src_en,
    output logic                          irq
);

    localparam int unsigned PINS   = NUM_PORTS * PORT_W;
    localparam int unsigned MODE_W = 2 * NUM_PORTS;

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] data;
        logic [NUM_PORTS-1:0][PORT_W-1:0] ie;
        logic [NUM_PORTS-1:0][PORT_W-1:0] flag;
        logic [NUM_PORTS-1:0][1:0]        mode;
    } regs_t;

    regs_t st_d, st_q;

    logic [PINS-1:0]   pin_lvl;
    logic [PINS-1:0]   pin_chg;
    logic [MODE_W-1:0] mode_vec;
    logic [PINS-1:0]   data_vec;

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_i (pad_in),
        .lvl_o (pin_lvl),
        .chg_o (pin_chg)
    );

    // next-state: register writes and sticky change flags
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            logic [PORT_W-1:0] clr;
            clr = '0;
            if (wr_en && addr == ADDR_W'(GP_DATA_BASE + p)) st_d.data[p] = wdata;
            if (wr_en && addr == ADDR_W'(GP_IE_BASE + p))   st_d.ie[p]   = wdata;
            if (wr_en && addr == ADDR_W'(GP_FLAG_BASE + p)) clr          = wdata;
            if (wr_en && addr == ADDR_W'(GP_MODE_ADDR))     st_d.mode[p] = wdata[2*p +: 2];
            // a fresh change outranks a clear in the same cycle
            st_d.flag[p] = (st_q.flag[p] & ~clr) | pin_chg[p*PORT_W +: PORT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '1;
            st_q.ie   <= '0;
            st_q.flag <= '0;
            st_q.mode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_vec = st_q.mode;
    assign data_vec = st_q.data;

    // read mux
    always_comb begin
        rdata = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (addr == ADDR_W'(GP_DATA_BASE + p)) rdata = pin_lvl[p*PORT_W +: PORT_W];
            if (addr == ADDR_W'(GP_IE_BASE + p))   rdata = st_q.ie[p];
            if (addr == ADDR_W'(GP_FLAG_BASE + p)) rdata = st_q.flag[p];
        end
        if (addr == ADDR_W'(GP_MODE_ADDR)) rdata[MODE_W-1:0] = mode_vec;
    end

    // per-port drive decode
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_pad_decode #(.PORT_W(PORT_W)) u_dec (
            .mode   (pad_mode_e'(st_q.mode[p])),
            .dout   (st_q.data[p]),
            .pull_o (pull_en[p*PORT_W +: PORT_W]),
            .sink_o (sink_en[p*PORT_W +: PORT_W]),
            .src_o  (src_en[p*PORT_W +: PORT_W])
        );
    end

    assign irq = |(st_q.flag & st_q.ie);

endmodule

// File: rtl/gpio_trio_chk.sv
module gpio_trio_chk #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [PORT_W-1:0]           wdata,
    input logic [NUM_PORTS*PORT_W-1:0] pull_en,
    input logic [NUM_PORTS*PORT_W-1:0] sink_en,
    input logic [NUM_PORTS*PORT_W-1:0] src_en,
    input logic                        irq,
    input logic [2*NUM_PORTS-1:0]      mode_vec,
    input logic [NUM_PORTS*PORT_W-1:0] data_vec
);

    // sink never fights pull-up or source
    assert_no_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_en & (pull_en | src_en)) == '0);

    // a set request stays up until software writes something
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(p)) |=> data_vec[p*PORT_W +: PORT_W] == $past(wdata));

        assert_pull_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (|pull_en[p*PORT_W +: PORT_W]) |-> mode_vec[2*p +: 2] == 2'b00);

        assert_src_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (|src_en[p*PORT_W +: PORT_W]) |-> mode_vec[2*p +: 2] == 2'b01);

        assert_float_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[2*p +: 2] == 2'b11) |->
            (pull_en[p*PORT_W +: PORT_W] | sink_en[p*PORT_W +: PORT_W]
             | src_en[p*PORT_W +: PORT_W]) == '0);
    end

endmodule

bind gpio_trio gpio_trio_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .pull_en  (pull_en),
    .sink_en  (sink_en),
    .src_en   (src_en),
    .irq      (irq),
    .mode_vec (mode_vec),
    .data_vec (data_vec)
);

// File: tb/gpio_trio_bench.sv
module gpio_trio_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] pad_in = '1;
    logic [23:0] pull_en, sink_en, src_en;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_data [3];
    logic [1:0] m_mode [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_trio u_gpio_trio (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pull_en(pull_en), .sink_en(sink_en),
        .src_en(src_en), .irq(irq)
    );

    function automatic logic [7:0] f_pull(input logic [1:0] m, input logic [7:0] d);
        return (m == 2'b00) ? d : 8'h00;
    endfunction
    function automatic logic [7:0] f_sink(input logic [1:0] m, input logic [7:0] d);
        return (m == 2'b11) ? 8'h00 : ~d;
    endfunction
    function automatic logic [7:0] f_src(input logic [1:0] m, input logic [7:0] d);
        return (m == 2'b01) ? d : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_drive(input string tag);
        for (int p = 0; p < 3; p++) begin
            chk({tag, " R3 pull"}, 32'(pull_en[p*8 +: 8]), 32'(f_pull(m_mode[p], m_data[p])));
            chk({tag, " R4 sink"}, 32'(sink_en[p*8 +: 8]), 32'(f_sink(m_mode[p], m_data[p])));
            chk({tag, " R5 src"},  32'(src_en[p*8 +: 8]),  32'(f_src(m_mode[p], m_data[p])));
        end
    endtask

    task automatic wr_mode;
        wr(8'h08, {2'b00, m_mode[2], m_mode[1], m_mode[0]});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [23:0] flags_m;
        void'($urandom(32'h5eed1234));
        for (int p = 0; p < 3; p++) begin m_data[p] = 8'hFF; m_mode[p] = 2'b00; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk("R8 pull", 32'(pull_en), 32'hFFFFFF);
        chk("R8 sink", 32'(sink_en), 32'h0);
        chk("R8 src",  32'(src_en),  32'h0);
        chk("R8 irq",  32'(irq),     32'h0);
        rd(8'h08, v); chk("R8 mode", 32'(v), 32'h0);
        rd(8'h05, v); chk("R8 ie", 32'(v), 32'h0);
        rd(8'h0C, v); chk("R8 flag", 32'(v), 32'h0);

        // directed: every mode on port 1 with a mixed pattern
        m_data[1] = 8'hA5; wr(8'h01, 8'hA5);
        check_drive("R1 latch");
        for (int m = 0; m < 4; m++) begin
            m_mode[1] = 2'(m); wr_mode;
            check_drive("R2 mode");
            rd(8'h08, v); chk("R2 readback", 32'(v), 32'(m << 2));
        end
        m_mode[1] = 2'b10; wr_mode;
        chk("R6 opendrain off", 32'((pull_en[15:8] | sink_en[15:8] | src_en[15:8]) & 8'hA5), 32'h0);

        // random latch and mode writes
        for (int i = 0; i < 60; i++) begin
            int p;
            logic [7:0] r;
            p = int'($urandom_range(0, 2));
            r = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                m_data[p] = r; wr(8'(p), r);
            end else begin
                m_mode[0] = r[1:0]; m_mode[1] = r[3:2]; m_mode[2] = r[5:4];
                wr(8'h08, r);
                rd(8'h08, v); chk("R2 rand readback", 32'(v), 32'(r[5:0]));
            end
            check_drive("R1 rand");
        end

        // R12 unmapped addresses
        wr(8'h03, 8'h00);
        wr(8'h30, 8'h00);
        check_drive("R12 write ignored");
        rd(8'h30, v); chk("R12 read zero", 32'(v), 32'h0);
        rd(8'h03, v); chk("R12 read zero 03", 32'(v), 32'h0);

        // R9 enables
        wr(8'h04, 8'h5A); wr(8'h05, 8'hC3); wr(8'h06, 8'h00);
        rd(8'h04, v); chk("R9 ie0", 32'(v), 32'h5A);
        rd(8'h05, v); chk("R9 ie1", 32'(v), 32'hC3);

        // R7 synchronizer latency on port 2
        @(negedge clk); pad_in[23:16] = 8'h3C;
        @(negedge clk); rd(8'h02, v); chk("R7 not yet", 32'(v), 32'hFF);
        @(negedge clk); rd(8'h02, v); chk("R7 visible", 32'(v), 32'h3C);
        @(negedge clk); rd(8'h0E, v); chk("R10 flags set", 32'(v), 32'hC3);
        chk("R11 masked irq", 32'(irq), 32'h0);
        wr(8'h06, 8'h01);
        chk("R11 irq up", 32'(irq), 32'h1);
        wr(8'h0E, 8'h01);
        rd(8'h0E, v); chk("R10 partial clear", 32'(v), 32'hC2);
        chk("R11 irq down", 32'(irq), 32'h0);
        wr(8'h0E, 8'hFF);
        rd(8'h0E, v); chk("R10 full clear", 32'(v), 32'h0);

        // R10 set wins over clear in the same cycle
        @(negedge clk); pad_in[16] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 8'h0E; wdata = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        rd(8'h0E, v); chk("R10 set beats clear", 32'(v), 32'h01);
        chk("R11 irq from race", 32'(irq), 32'h1);
        wr(8'h0E, 8'hFF);

        // random pad changes on all ports
        wr(8'h04, 8'hFF); wr(8'h05, 8'hFF); wr(8'h06, 8'hFF);
        for (int i = 0; i < 12; i++) begin
            logic [23:0] nv;
            nv = 24'($urandom);
            flags_m = pad_in ^ nv;
            @(negedge clk); pad_in = nv;
            repeat (3) @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                rd(8'(p), v);      chk("R7 rand level", 32'(v), 32'(nv[p*8 +: 8]));
                rd(8'(12 + p), v); chk("R10 rand flag", 32'(v), 32'(flags_m[p*8 +: 8]));
            end
            chk("R11 rand irq", 32'(irq), 32'(flags_m != 0));
            for (int p = 0; p < 3; p++) wr(8'(12 + p), 8'hFF);
            chk("R11 irq cleared", 32'(irq), 32'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule